// File: doc/BRIEF.md
# Paged Virtual Address Relocation Unit

This unit turns a 16-bit virtual byte address from the processor into an 18-bit physical bus address. The top three virtual address bits pick one of eight page slots. Each slot holds a base value and a descriptor. The descriptor gives a page length in 32-word blocks, whether the page grows upward or downward, and its access rights. Kernel mode and user mode each have their own set of eight slots, and the mode flag on each request picks which set is used. A request that breaks a descriptor's rules is refused with an abort and a reason code, and no address is given.

Software loads the slots through a single write port. The same port also switches relocation on or off. While relocation is off, the unit passes the virtual address through. The top 8 KB of virtual space is placed at the top of physical space, and every other address gets zero high bits. Relocation runs as a two-state machine. `RELOC_OFF` is the reset state, and a control write with data bit 0 set takes the `ENABLE` transition to `RELOC_ON`. A control write with bit 0 clear takes the `DISABLE` transition back to `RELOC_OFF`. Any other write leaves the state where it is.

The address path is combinational from the stored registers. The result is registered, so each request gets its response exactly one cycle later.

Top module: `vaddr_reloc_unit`

## Requirements
- R1: After reset, `rsp_valid` is low and relocation is off. Every descriptor reads as non-resident, so enabling relocation before any descriptor write makes every request abort with reason 1.
- R2: With relocation off, a virtual address below 160000 (octal) gives a physical address equal to the virtual address with bits 17:16 zero, and no abort.
- R3: With relocation off, virtual addresses 160000 to 177777 (octal) give the virtual address with bits 17:16 forced to 11, and no abort.
- R4: With relocation on and no abort, the physical address is (base << 6) + vaddr[12:0], truncated to 18 bits. Base is write data bits 11:0 of a base write (`cfg_kind` = 0).
- R5: The slot used is {mode, vaddr[15:13]}, where mode is `req_user` (1 = user set, 0 = kernel set). For example, virtual 120000 in a kernel slot 5 with base 3200 gives 320000 (all octal).
- R6: A descriptor is loaded by a write with `cfg_kind` = 1. Its length sits in bits 14:8 and its direction in bit 3 (0 = upward). An upward page aborts with reason 2 when vaddr[12:6] is greater than the length.
- R7: A downward page (direction bit 1) aborts with reason 2 when vaddr[12:6] is less than the length.
- R8: The access field is descriptor bits 1:0. Values 00 and 10 mean non-resident, and any access to such a page aborts with reason 1. This check takes priority over the length and write checks.
- R9: Access value 01 is read-only: a write to it aborts with reason 3 and a read succeeds. Access value 11 allows both reads and writes.
- R10: A request is answered on the next clock edge. A register or control write (`cfg_kind` = 2, data bit 0 = enable) first affects requests issued in the cycle after the write. A request issued in the same cycle as the write still sees the old value.
- R11: An aborted response drives `rsp_paddr` to zero and a nonzero reason. A successful response drives reason 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_kind | input | 2 | 0 base, 1 descriptor, 2 control, 3 ignored |
| cfg_mode | input | 1 | Register set written (1 = user) |
| cfg_page | input | 3 | Page slot written |
| cfg_wdata | input | 16 | Write data |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 16 | Virtual byte address |
| req_user | input | 1 | Mode of the request (1 = user) |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_paddr | output | 18 | Physical address (zero on abort) |
| rsp_abort | output | 1 | Request refused |
| rsp_reason | output | 2 | 0 ok, 1 non-resident, 2 length, 3 read-only |

## Verification
The assertions check on every cycle:
- the one-cycle response timing;
- that a response aborts exactly when its reason is nonzero, with the address zeroed on abort;
- both bypass mappings while relocation is off;
- that a control write lands in the state machine on the next edge.

Only the bench's sweeps can show the rest: that base arithmetic and 18-bit wraparound are right, that each mode selects its own slots, that both length boundaries fall on the exact block, that the abort reasons follow their priority, and that a write issued together with a request is not seen by that request.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
    localparam int LEN_W = 7;

    typedef enum logic [1:0] {
        ACC_ABSENT  = 2'b00,
        ACC_RDONLY  = 2'b01,
        ACC_ABSENT2 = 2'b10,
        ACC_RDWR    = 2'b11
    } acc_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             down;
        acc_e             acc;
    } pdesc_t;

    typedef enum logic [1:0] {
        RSN_NONE   = 2'd0,
        RSN_ABSENT = 2'd1,
        RSN_LENGTH = 2'd2,
        RSN_RDONLY = 2'd3
    } reason_e;

    typedef enum logic [1:0] {
        CFG_BASE  = 2'd0,
        CFG_DESC  = 2'd1,
        CFG_CTRL  = 2'd2,
        CFG_SPARE = 2'd3
    } cfg_kind_e;

    typedef enum logic {
        RELOC_OFF = 1'b0,
        RELOC_ON  = 1'b1
    } reloc_state_e;
endpackage

// File: rtl/reloc_mode_fsm.sv
module reloc_mode_fsm
    import reloc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [1:0] cfg_kind,
    input  logic       cfg_en,
    output logic       reloc_on
);
    reloc_state_e state_q, state_d;
    logic ctrl_wr;

    assign ctrl_wr = cfg_we && (cfg_kind == CFG_CTRL);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RELOC_OFF: if (ctrl_wr && cfg_en)  state_d = RELOC_ON;   // ENABLE
            RELOC_ON:  if (ctrl_wr && !cfg_en) state_d = RELOC_OFF;  // DISABLE
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RELOC_OFF;
        else        state_q <= state_d;
    end

    always_comb reloc_on = (state_q == RELOC_ON);

    p_ctrl_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_kind == CFG_CTRL) |=> (reloc_on == $past(cfg_en)));
endmodule

// File: rtl/page_reg_bank.sv
module page_reg_bank
    import reloc_pkg::*;
#(
    parameter int PG_W   = 3,
    parameter int BASE_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_kind,
    input  logic              cfg_mode,
    input  logic [PG_W-1:0]   cfg_page,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              rd_mode,
    input  logic [PG_W-1:0]   rd_page,
    output logic [BASE_W-1:0] rd_base,
    output pdesc_t            rd_desc
);
    localparam int NSLOT = 2 << PG_W;
    localparam int IDX_W = PG_W + 1;

    logic [BASE_W-1:0] base_q [NSLOT];
    pdesc_t            desc_q [NSLOT];
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    pdesc_t            wr_desc;
    logic              unused_bits;

    assign wr_idx  = {cfg_mode, cfg_page};
    assign rd_idx  = {rd_mode, rd_page};
    assign wr_desc = '{len:  cfg_wdata[8 +: LEN_W],
                       down: cfg_wdata[3],
                       acc:  acc_e'(cfg_wdata[1:0])};
    assign unused_bits = ^{cfg_wdata[DATA_W-1:8+LEN_W], cfg_wdata[7:4], cfg_wdata[2]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < NSLOT; e++) begin
                base_q[e] <= '0;
                desc_q[e] <= '{len: '0, down: 1'b0, acc: ACC_ABSENT};
            end
        end else if (cfg_we) begin
            if (cfg_kind == CFG_BASE) base_q[wr_idx] <= cfg_wdata[BASE_W-1:0];
            if (cfg_kind == CFG_DESC) desc_q[wr_idx] <= wr_desc;
        end
    end

    assign rd_base = base_q[rd_idx];
    assign rd_desc = desc_q[rd_idx];
endmodule

// File: rtl/page_xlate.sv
module page_xlate
    import reloc_pkg::*;
#(
    parameter int VA_W      = 16,
    parameter int PA_W      = 18,
    parameter int PG_W      = 3,
    parameter int BLK_SHIFT = 6
) (
    input  logic                     reloc_on,
    input  logic [VA_W-1:0]          vaddr,
    input  logic                     is_write,
    input  logic [PA_W-BLK_SHIFT-1:0] base,
    input  pdesc_t                   desc,
    output logic [PA_W-1:0]          paddr,
    output logic                     abort,
    output reason_e                  reason
);
    localparam int OFF_W = VA_W - PG_W;
    localparam int HI_W  = PA_W - VA_W;

    logic [LEN_W-1:0] blk;
    logic [PA_W-1:0]  reloc_addr, bypass_addr;
    logic             io_top, len_bad;

    always_comb begin
        blk         = vaddr[OFF_W-1:BLK_SHIFT];
        reloc_addr  = {base, {BLK_SHIFT{1'b0}}} + PA_W'(vaddr[OFF_W-1:0]);
        io_top      = &vaddr[VA_W-1:OFF_W];
        bypass_addr = {{HI_W{io_top}}, vaddr};
        len_bad     = desc.down ? (blk < desc.len) : (blk > desc.len);
        reason      = RSN_NONE;
        if (reloc_on) begin
            if (!desc.acc[0])                        reason = RSN_ABSENT;
            else if (len_bad)                        reason = RSN_LENGTH;
            else if (is_write && desc.acc != ACC_RDWR) reason = RSN_RDONLY;
        end
        abort = (reason != RSN_NONE);
        if (!reloc_on)  paddr = bypass_addr;
        else if (abort) paddr = '0;
        else            paddr = reloc_addr;
    end
endmodule

// File: rtl/vaddr_reloc_unit.sv
module vaddr_reloc_unit
    import reloc_pkg::*;
#(
    parameter int VA_W      = 16,
    parameter int PA_W      = 18,
    parameter int PG_W      = 3,
    parameter int BLK_SHIFT = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_kind,
    input  logic            cfg_mode,
    input  logic [PG_W-1:0] cfg_page,
    input  logic [15:0]     cfg_wdata,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic            req_user,
    input  logic            req_write,
    output logic            rsp_valid,
    output logic [PA_W-1:0] rsp_paddr,
    output logic            rsp_abort,
    output logic [1:0]      rsp_reason
);
    localparam int BASE_W = PA_W - BLK_SHIFT;
    localparam int OFF_W  = VA_W - PG_W;

    logic              reloc_on;
    logic [BASE_W-1:0] sel_base;
    pdesc_t            sel_desc;
    logic [PA_W-1:0]   xl_paddr;
    logic              xl_abort;
    reason_e           xl_reason;

    reloc_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_en(cfg_wdata[0]), .reloc_on(reloc_on)
    );

    page_reg_bank #(.PG_W(PG_W), .BASE_W(BASE_W), .DATA_W(16)) u_bank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_mode(cfg_mode), .cfg_page(cfg_page), .cfg_wdata(cfg_wdata),
        .rd_mode(req_user), .rd_page(req_vaddr[VA_W-1:OFF_W]),
        .rd_base(sel_base), .rd_desc(sel_desc)
    );

    page_xlate #(.VA_W(VA_W), .PA_W(PA_W), .PG_W(PG_W), .BLK_SHIFT(BLK_SHIFT)) u_xl (
        .reloc_on(reloc_on), .vaddr(req_vaddr), .is_write(req_write),
        .base(sel_base), .desc(sel_desc),
        .paddr(xl_paddr), .abort(xl_abort), .reason(xl_reason)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_paddr  <= '0;
            rsp_abort  <= 1'b0;
            rsp_reason <= RSN_NONE;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_paddr  <= xl_paddr;
                rsp_abort  <= xl_abort;
                rsp_reason <= xl_reason;
            end
        end
    end

    p_answer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_abort_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_abort) |-> (rsp_paddr == '0 && rsp_reason != RSN_NONE));
    p_ok_reason_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_abort) |-> (rsp_reason == RSN_NONE));
    p_bypass_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!reloc_on && req_valid && (&req_vaddr[VA_W-1:OFF_W]))
        |=> (rsp_paddr == {2'b11, $past(req_vaddr)} && !rsp_abort));
    p_bypass_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!reloc_on && req_valid && !(&req_vaddr[VA_W-1:OFF_W]))
        |=> (rsp_paddr == {2'b00, $past(req_vaddr)} && !rsp_abort));
endmodule

// File: tb/tb_vaddr_reloc_unit.sv
`timescale 1ns/1ps
module tb_vaddr_reloc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_kind = 2'd0;
    logic        cfg_mode = 1'b0;
    logic [2:0]  cfg_page = 3'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        req_valid = 1'b0;
    logic [15:0] req_vaddr = 16'd0;
    logic        req_user = 1'b0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [17:0] rsp_paddr;
    logic        rsp_abort;
    logic [1:0]  rsp_reason;

    int n_chk = 0;
    int n_fail = 0;

    logic [11:0] m_base [16];
    logic [6:0]  m_len  [16];
    logic        m_down [16];
    logic [1:0]  m_acc  [16];
    logic        m_on;

    always #2.5 clk = ~clk;

    vaddr_reloc_unit dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_mode(cfg_mode), .cfg_page(cfg_page), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_user(req_user),
        .req_write(req_write), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_abort(rsp_abort), .rsp_reason(rsp_reason)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic check(input string tag, input logic [20:0] act, input logic [20:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [20:0] model(input logic [15:0] va, input logic usr, input logic wr,
                                          output string tag);
        logic [3:0]  idx;
        logic [6:0]  blk;
        logic [1:0]  rs;
        logic [17:0] pa;
        idx = {usr, va[15:13]};
        blk = va[12:6];
        rs  = 2'd0;
        if (!m_on) begin
            pa  = {(va[15:13] == 3'b111) ? 2'b11 : 2'b00, va};
            tag = (va[15:13] == 3'b111) ? "R3 bypass top" : "R2 bypass low";
        end else begin
            tag = usr ? "R4/R5 user map" : "R4/R5 kernel map";
            if (m_acc[idx][0] == 1'b0) begin rs = 2'd1; tag = "R8 non-resident"; end
            else if (!m_down[idx] && blk > m_len[idx]) begin rs = 2'd2; tag = "R6 upward length"; end
            else if (m_down[idx] && blk < m_len[idx]) begin rs = 2'd2; tag = "R7 downward length"; end
            else if (wr && m_acc[idx] != 2'b11) begin rs = 2'd3; tag = "R9 read-only write"; end
            pa = (rs != 2'd0) ? 18'd0 : 18'({m_base[idx], 6'd0} + {5'd0, va[12:0]});
        end
        return {(rs != 2'd0), rs, pa};
    endfunction

    task automatic cfg_write(input logic [1:0] kind, input logic md, input logic [2:0] pg,
                             input logic [15:0] d);
        cfg_we = 1'b1; cfg_kind = kind; cfg_mode = md; cfg_page = pg; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (kind)
            2'd0: m_base[{md, pg}] = d[11:0];
            2'd1: begin m_len[{md, pg}] = d[14:8]; m_down[{md, pg}] = d[3]; m_acc[{md, pg}] = d[1:0]; end
            2'd2: m_on = d[0];
            default: ;
        endcase
    endtask

    function automatic logic [15:0] dword(input logic [6:0] len, input logic dn, input logic [1:0] acc);
        return {1'b0, len, 4'b0, dn, 1'b0, acc};
    endfunction

    task automatic xlate(input logic [15:0] va, input logic usr, input logic wr);
        string tag;
        logic [20:0] exp;
        exp = model(va, usr, wr, tag);
        req_valid = 1'b1; req_vaddr = va; req_user = usr; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R10 valid"}, {20'd0, rsp_valid}, 21'd1);
        check(tag, {rsp_abort, rsp_reason, rsp_paddr}, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R10 watchdog: actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_base[i] = '0; m_len[i] = '0; m_down[i] = 1'b0; m_acc[i] = 2'b00;
        end
        m_on = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {20'd0, rsp_valid}, 21'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {20'd0, rsp_valid}, 21'd0);

        // R1: descriptors reset to non-resident
        cfg_write(2'd2, 1'b0, 3'd0, 16'h0001);
        xlate(16'h0000, 1'b0, 1'b0);
        xlate(16'o120000, 1'b1, 1'b1);
        cfg_write(2'd2, 1'b0, 3'd0, 16'h0000);

        // R2/R3 bypass sweep
        for (int i = 0; i < 512; i++)
            xlate(16'(i * 128 + (i % 128)), i[0], i[1]);
        xlate(16'o157777, 1'b0, 1'b0);
        xlate(16'o160000, 1'b0, 1'b1);
        xlate(16'o177777, 1'b1, 1'b0);

        // R5 worked example
        cfg_write(2'd0, 1'b0, 3'd5, 16'o3200);
        cfg_write(2'd1, 1'b0, 3'd5, dword(7'd127, 1'b0, 2'b11));
        cfg_write(2'd0, 1'b1, 3'd5, 16'o1000);
        cfg_write(2'd1, 1'b1, 3'd5, dword(7'd127, 1'b0, 2'b11));
        cfg_write(2'd2, 1'b0, 3'd0, 16'h0001);
        req_valid = 1'b1; req_vaddr = 16'o120000; req_user = 1'b0; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R5 example 120000->320000", {3'b000, rsp_paddr}, {3'b000, 18'o320000});
        xlate(16'o120000, 1'b1, 1'b0);

        // full configuration of both sets
        for (int md = 0; md < 2; md++) begin
            for (int pg = 0; pg < 8; pg++) begin
                logic [1:0] acc;
                logic [11:0] b;
                acc = (pg % 4 == 0) ? 2'b00 : (pg % 4 == 1) ? 2'b01 : (pg % 4 == 2) ? 2'b10 : 2'b11;
                b = 12'((md * 8 + pg) * 12'h1A7 + 12'h0F3);
                if (md == 1 && pg == 3) b = 12'hFFF;
                cfg_write(2'd0, md[0], pg[2:0], {4'hA, b});
                cfg_write(2'd1, md[0], pg[2:0],
                          dword(7'((pg * 37 + md * 11) % 128), pg[2] ^ md[0], acc));
            end
        end

        // R4..R9 near-exhaustive block sweep
        for (int md = 0; md < 2; md++)
            for (int pg = 0; pg < 8; pg++)
                for (int blk = 0; blk < 128; blk++)
                    for (int wr = 0; wr < 2; wr++)
                        xlate({pg[2:0], blk[6:0], 6'((blk * 5 + pg) & 63)}, md[0], wr[0]);

        // R10: write and request in the same cycle sees old base
        begin
            string tag;
            logic [20:0] exp;
            exp = model(16'h2040, 1'b0, 1'b0, tag);
            cfg_we = 1'b1; cfg_kind = 2'd0; cfg_mode = 1'b0; cfg_page = 3'd1; cfg_wdata = 16'h0123;
            req_valid = 1'b1; req_vaddr = 16'h2040; req_user = 1'b0; req_write = 1'b0;
            @(negedge clk);
            cfg_we = 1'b0; req_valid = 1'b0;
            check("R10 same-cycle write not seen", {rsp_abort, rsp_reason, rsp_paddr}, exp);
            m_base[1] = 12'h123;
            xlate(16'h2040, 1'b0, 1'b0);
        end

        // R10: disable lands next cycle
        cfg_write(2'd2, 1'b0, 3'd0, 16'h0000);
        xlate(16'o170000, 1'b0, 1'b1);

        summary();
        $finish;
    end
endmodule